// File: doc/BRIEF.md
# Unaligned DMA Byte Aligner

This block moves a run of bytes from a source region into a destination region when neither start address is a multiple of the word size. It reads the source as whole 64-bit words, always with every byte lane enabled. It steps the read address one word at a time and keeps a count of the useful bytes still to come. It lines the data up to the destination offset and emits 64-bit words, each with an 8-bit byte-enable mask. The mask trims the first and last destination words, so only the requested bytes are written.

A transfer begins with a one-cycle `start` pulse that carries the source address, the destination address and the byte count. The block then pulls source words through a valid/ready input stream and pushes aligned words through a valid/ready output stream, together with the destination word address of each word. The two streams are coupled, so once the pipe is running one word passes per cycle while both sides are willing.

Control is a five-state machine:
- IDLE waits for `start`. It goes to DONE when the count is zero, to PRIME when the source offset is larger than the destination offset, and to STREAM in every other case.
- PRIME reads the first source word and produces no output. From there it goes to STREAM, or to FLUSH when that word was the only one to read.
- STREAM consumes one source word and emits one output word per handshake. It goes to DONE after the last output word, or to FLUSH once the last source word has been read while one output word is still owed.
- FLUSH emits that final word from the held source bytes alone and goes to DONE.
- DONE raises `done` for one cycle and returns to IDLE.

Top module: `dma_align`

## Requirements
- R1: A start with byte count 0 produces no input or output handshake, and `done` is high in the cycle right after the start edge.
- R2: Source words are requested at `rd_addr` values that begin at the source address rounded down to a multiple of 8 and rise by 8 with each accepted input word. `rd_addr` bits [2:0] are always 0.
- R3: `rd_remain` equals the byte count when the first word is read. Each accepted word lowers it by min(8 − source offset, remaining) for the first word and by min(8, remaining) for later words. It is 0 when `done` is high and never rises during a transfer.
- R4: Output word j carries `out_addr` = destination address rounded down to a multiple of 8, plus 8·j.
- R5: The destination byte at address dst+i holds the source byte at address src+i, for 0 ≤ i < count. Byte lane b of a word holds address offset b, so bits [8b+7:8b] hold that byte.
- R6: `out_be` bit b is set exactly when destination address (out_addr + b) lies inside [dst, dst+count). In the first word that means lanes at or above the destination offset. In the last word it means lanes below (dst+count) mod 8, or all lanes when that value is 0. Every middle word is 8'hFF.
- R7: A transfer accepts exactly ceil((src mod 8 + count)/8) input words and emits exactly ceil((dst mod 8 + count)/8) output words.
- R8: With input valid and output ready held high, `done` comes nout + p + 1 cycles after the start edge. Here nout is the output word count, and p is 1 when the source offset exceeds the destination offset (the PRIME cycle) and 0 otherwise.
- R9: A `start` pulse while a transfer is under way is ignored: the running transfer completes with the addresses, data and counts of R2–R7.
- R10: After reset and after every `done` cycle the block is idle: `busy`, `done`, `in_ready` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a transfer |
| src_addr | input | 32 | Byte address of the first source byte |
| dst_addr | input | 32 | Byte address of the first destination byte |
| byte_count | input | 16 | Number of bytes to move |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when the transfer has finished |
| in_valid | input | 1 | A source word is present on in_data |
| in_ready | output | 1 | The block takes the source word this cycle |
| in_data | input | 64 | Source word read from rd_addr |
| rd_addr | output | 32 | Word-aligned byte address of the next source word |
| rd_remain | output | 16 | Useful source bytes not yet read |
| out_valid | output | 1 | An aligned output word is present |
| out_ready | input | 1 | The sink takes the output word this cycle |
| out_data | output | 64 | Aligned output word |
| out_be | output | 8 | Per-lane write enables for out_data |
| out_addr | output | 32 | Word-aligned destination byte address of out_data |

## Verification
The hardest situation to reach is the last output word being owed after the last source word has been consumed. This only happens for certain pairs of offsets and counts. It can follow either the PRIME path, where the source offset is ahead, or the direct path, where the destination offset is ahead. In addition, the sink must stall at that moment, so that FLUSH has to hold its word. The stimulus sweeps offset pairs on both sides of equality, with counts chosen so that the tail falls just inside and just beyond a word boundary. It runs each pair once at full rate and once with random input gaps and output back-pressure. A stray start pulse is injected during one long transfer.

// File: rtl/dma_align_pkg.sv
package dma_align_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRIME,
        ST_STREAM,
        ST_FLUSH,
        ST_DONE
    } dal_state_e;

endpackage

// File: rtl/dma_align_ctrl.sv
module dma_align_ctrl
    import dma_align_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [ADDR_W-1:0]             src_addr,
    input  logic [ADDR_W-1:0]             dst_addr,
    input  logic [CNT_W-1:0]              byte_count,
    input  logic                          in_valid,
    input  logic [DATA_W-1:0]             in_data,
    input  logic                          out_ready,
    output logic                          in_ready,
    output logic                          out_valid,
    output logic                          busy,
    output logic                          done,
    output logic [ADDR_W-1:0]             rd_addr,
    output logic [CNT_W-1:0]              rd_remain,
    output logic [ADDR_W-1:0]             out_addr,
    output logic [DATA_W-1:0]             held_word,
    output logic                          flush_sel,
    output logic [$clog2(DATA_W/8):0]     shift_amt,
    output logic                          first_word,
    output logic                          last_word,
    output logic [$clog2(DATA_W/8)-1:0]   dst_lane,
    output logic [$clog2(DATA_W/8):0]     tail_len
);

    localparam int BYTES = DATA_W / 8;
    localparam int OFF_W = $clog2(BYTES);
    localparam int SH_W  = OFF_W + 1;
    localparam int WA_W  = ADDR_W - OFF_W;
    localparam int WC_W  = CNT_W + 1;

    dal_state_e state, nxt;

    logic [OFF_W-1:0]  s_off, d_off;
    logic [WA_W-1:0]   rd_word, wr_word;
    logic [WC_W-1:0]   rd_left, wr_left;
    logic [CNT_W-1:0]  rd_rem;
    logic              first_rd, first_wr;
    logic [DATA_W-1:0] carry;
    logic [SH_W-1:0]   shift_r, tail_r;

    // Values derived from the start request
    logic [OFF_W-1:0]  so_n, do_n, tail_lo;
    logic [WC_W-1:0]   span_in, span_out;
    logic              lead_n;
    logic [SH_W-1:0]   shift_n, tail_n;

    always_comb begin
        so_n     = src_addr[OFF_W-1:0];
        do_n     = dst_addr[OFF_W-1:0];
        span_in  = ({1'b0, byte_count} + WC_W'(so_n) + WC_W'(BYTES - 1)) >> OFF_W;
        span_out = ({1'b0, byte_count} + WC_W'(do_n) + WC_W'(BYTES - 1)) >> OFF_W;
        lead_n   = so_n > do_n;
        shift_n  = lead_n ? SH_W'(so_n - do_n) : (SH_W'(BYTES) - SH_W'(do_n - so_n));
        tail_lo  = do_n + byte_count[OFF_W-1:0];
        tail_n   = (tail_lo == '0) ? SH_W'(BYTES) : {1'b0, tail_lo};
    end

    logic take_in, give_out;
    assign take_in  = in_valid & in_ready;
    assign give_out = out_valid & out_ready;

    // Useful bytes carried by the word being read
    logic [SH_W-1:0]  head;
    logic [CNT_W-1:0] used;
    always_comb begin
        head = first_rd ? (SH_W'(BYTES) - {1'b0, s_off}) : SH_W'(BYTES);
        used = (CNT_W'(head) < rd_rem) ? CNT_W'(head) : rd_rem;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (byte_count == '0)                nxt = ST_DONE;
                    else if (src_addr[OFF_W-1:0] > do_n) nxt = ST_PRIME;
                    else                                 nxt = ST_STREAM;
                end
            end
            ST_PRIME: begin
                if (take_in) nxt = (rd_left == WC_W'(1)) ? ST_FLUSH : ST_STREAM;
            end
            ST_STREAM: begin
                if (give_out) begin
                    if (wr_left == WC_W'(1))      nxt = ST_DONE;
                    else if (rd_left == WC_W'(1)) nxt = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                if (out_ready) nxt = ST_DONE;
            end
            ST_DONE: nxt = ST_IDLE;
        endcase
    end

    // Output decode per state
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_PRIME:  in_ready = 1'b1;
            ST_STREAM: begin
                in_ready  = out_ready;
                out_valid = in_valid;
            end
            ST_FLUSH:  out_valid = 1'b1;
            ST_DONE:   done = 1'b1;
        endcase
    end

    assign busy = (state != ST_IDLE);

    // Address, count and carry registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_off    <= '0;
            d_off    <= '0;
            rd_word  <= '0;
            wr_word  <= '0;
            rd_left  <= '0;
            wr_left  <= '0;
            rd_rem   <= '0;
            first_rd <= 1'b0;
            first_wr <= 1'b0;
            carry    <= '0;
            shift_r  <= '0;
            tail_r   <= '0;
        end else if (state == ST_IDLE) begin
            if (start) begin
                s_off    <= so_n;
                d_off    <= do_n;
                rd_word  <= src_addr[ADDR_W-1:OFF_W];
                wr_word  <= dst_addr[ADDR_W-1:OFF_W];
                rd_left  <= span_in;
                wr_left  <= span_out;
                rd_rem   <= byte_count;
                first_rd <= 1'b1;
                first_wr <= 1'b1;
                carry    <= '0;
                shift_r  <= shift_n;
                tail_r   <= tail_n;
            end
        end else begin
            if (take_in) begin
                carry    <= in_data;
                rd_word  <= rd_word + 1'b1;
                rd_left  <= rd_left - 1'b1;
                rd_rem   <= rd_rem - used;
                first_rd <= 1'b0;
            end
            if (give_out) begin
                wr_word  <= wr_word + 1'b1;
                wr_left  <= wr_left - 1'b1;
                first_wr <= 1'b0;
            end
        end
    end

    assign rd_addr    = {rd_word, {OFF_W{1'b0}}};
    assign out_addr   = {wr_word, {OFF_W{1'b0}}};
    assign rd_remain  = rd_rem;
    assign held_word  = carry;
    assign flush_sel  = (state == ST_FLUSH);
    assign shift_amt  = shift_r;
    assign first_word = first_wr;
    assign last_word  = (wr_left == WC_W'(1));
    assign dst_lane   = d_off;
    assign tail_len   = tail_r;

endmodule

// File: rtl/dma_align_shift.sv
module dma_align_shift #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]         new_word,
    input  logic [DATA_W-1:0]         old_word,
    input  logic                      flush,
    input  logic [$clog2(DATA_W/8):0] shift_amt,
    output logic [DATA_W-1:0]         word_o
);

    logic [2*DATA_W-1:0] window, moved;

    // Newer word in the upper half, previous word in the lower half
    always_comb begin
        window = {(flush ? {DATA_W{1'b0}} : new_word), old_word};
        moved  = window >> {shift_amt, 3'b000};
        word_o = moved[DATA_W-1:0];
    end

endmodule

// File: rtl/dma_align_mask.sv
module dma_align_mask #(
    parameter int DATA_W = 64
) (
    input  logic                        first_word,
    input  logic                        last_word,
    input  logic [$clog2(DATA_W/8)-1:0] dst_lane,
    input  logic [$clog2(DATA_W/8):0]   tail_len,
    output logic [DATA_W/8-1:0]         be
);

    localparam int BYTES = DATA_W / 8;
    localparam int SH_W  = $clog2(BYTES) + 1;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        localparam logic [SH_W-1:0] LANE = SH_W'(b);
        logic head_ok, tail_ok;
        assign head_ok = !first_word || ({1'b0, dst_lane} <= LANE);
        assign tail_ok = !last_word  || (LANE < tail_len);
        assign be[b]   = head_ok & tail_ok;
    end

endmodule

// File: rtl/dma_align.sv
module dma_align #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [ADDR_W-1:0]     src_addr,
    input  logic [ADDR_W-1:0]     dst_addr,
    input  logic [CNT_W-1:0]      byte_count,
    output logic                  busy,
    output logic                  done,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [DATA_W-1:0]     in_data,
    output logic [ADDR_W-1:0]     rd_addr,
    output logic [CNT_W-1:0]      rd_remain,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [DATA_W-1:0]     out_data,
    output logic [DATA_W/8-1:0]   out_be,
    output logic [ADDR_W-1:0]     out_addr
);

    localparam int OFF_W = $clog2(DATA_W / 8);

    logic [DATA_W-1:0] held_word;
    logic              flush_sel, first_word, last_word;
    logic [OFF_W:0]    shift_amt, tail_len;
    logic [OFF_W-1:0]  dst_lane;

    dma_align_ctrl #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .src_addr   (src_addr),
        .dst_addr   (dst_addr),
        .byte_count (byte_count),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .out_ready  (out_ready),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .busy       (busy),
        .done       (done),
        .rd_addr    (rd_addr),
        .rd_remain  (rd_remain),
        .out_addr   (out_addr),
        .held_word  (held_word),
        .flush_sel  (flush_sel),
        .shift_amt  (shift_amt),
        .first_word (first_word),
        .last_word  (last_word),
        .dst_lane   (dst_lane),
        .tail_len   (tail_len)
    );

    dma_align_shift #(.DATA_W(DATA_W)) u_shift (
        .new_word  (in_data),
        .old_word  (held_word),
        .flush     (flush_sel),
        .shift_amt (shift_amt),
        .word_o    (out_data)
    );

    dma_align_mask #(.DATA_W(DATA_W)) u_mask (
        .first_word (first_word),
        .last_word  (last_word),
        .dst_lane   (dst_lane),
        .tail_len   (tail_len),
        .be         (out_be)
    );

endmodule

// File: rtl/dma_align_chk.sv
module dma_align_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [CNT_W-1:0]    byte_count,
    input logic                busy,
    input logic                done,
    input logic                in_valid,
    input logic                in_ready,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic [CNT_W-1:0]    rd_remain,
    input logic                out_valid,
    input logic                out_ready,
    input logic [DATA_W/8-1:0] out_be,
    input logic [ADDR_W-1:0]   out_addr
);

    localparam int BYTES = DATA_W / 8;

    p_zero_count_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && byte_count == '0) |=> done);

    p_read_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (rd_addr == $past(rd_addr) + ADDR_W'(BYTES)));

    p_remain_never_rises_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (rd_remain <= $past(rd_remain)));

    p_remain_empty_at_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rd_remain == '0));

    p_write_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (out_addr == $past(out_addr) + ADDR_W'(BYTES)));

    p_enables_present_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_be != '0));

    p_start_busy_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !done) |=> busy);

    p_idle_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !in_ready && !out_valid));

endmodule

bind dma_align dma_align_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .byte_count (byte_count),
    .busy       (busy),
    .done       (done),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .rd_addr    (rd_addr),
    .rd_remain  (rd_remain),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_be     (out_be),
    .out_addr   (out_addr)
);

// File: tb/tb_dma_align.sv
module tb_dma_align;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] src_addr = '0, dst_addr = '0;
    logic [15:0] byte_count = '0;
    logic        busy, done, in_ready, out_valid;
    logic        in_valid = 1'b0, out_ready = 1'b0;
    logic [63:0] in_data, out_data;
    logic [31:0] rd_addr, out_addr;
    logic [15:0] rd_remain;
    logic [7:0]  out_be;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dma_align dut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr),
        .dst_addr(dst_addr), .byte_count(byte_count), .busy(busy), .done(done),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .rd_addr(rd_addr), .rd_remain(rd_remain), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_be(out_be),
        .out_addr(out_addr)
    );

    // Source memory: every byte address holds a known value
    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5A;
    endfunction

    always_comb begin
        for (int k = 0; k < 8; k++) in_data[8*k +: 8] = mem_byte(rd_addr + 32'(k));
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic xfer(input int src, input int dst, input int n,
                        input int pv, input int pr, input bit poke);
        logic [31:0] q_addr[$];
        logic [63:0] q_data[$];
        logic [7:0]  q_be[$];
        int so, dof, nin, nout, lead, rk, rem, iter, used;
        logic [31:0] rbase;
        so    = src % 8;
        dof   = dst % 8;
        nin   = (n == 0) ? 0 : (so + n + 7) / 8;
        nout  = (n == 0) ? 0 : (dof + n + 7) / 8;
        lead  = (so > dof) ? 1 : 0;
        rbase = 32'(src - so);
        for (int j = 0; j < nout; j++) begin
            logic [63:0] d;
            logic [7:0]  e;
            d = '0;
            e = '0;
            for (int b = 0; b < 8; b++) begin
                int pos;
                pos = 8*j + b - dof;
                if (pos >= 0 && pos < n) begin
                    e[b]       = 1'b1;
                    d[8*b +: 8] = mem_byte(32'(src + pos));
                end
            end
            q_addr.push_back(32'(dst - dof + 8*j));
            q_data.push_back(d);
            q_be.push_back(e);
        end
        rk  = 0;
        rem = n;

        @(negedge clk);
        start      = 1'b1;
        src_addr   = 32'(src);
        dst_addr   = 32'(dst);
        byte_count = 16'(n);
        in_valid   = 1'b0;
        out_ready  = 1'b0;
        #4;
        check(!busy && !done, "R10 idle before start", {62'b0, busy, done}, 64'd0);
        iter = 0;
        forever begin
            @(negedge clk);
            iter++;
            start = poke && (iter == 2);
            if (start) begin
                src_addr   = 32'h0000_1003;
                dst_addr   = 32'h0000_2006;
                byte_count = 16'd5;
            end
            in_valid  = ($urandom_range(0, 99) < pv);
            out_ready = ($urandom_range(0, 99) < pr);
            #4;
            if (in_valid && in_ready) begin
                check(rk < nin, "R7 extra read", 64'(rk), 64'(nin));
                check(rd_addr == rbase + 32'(8*rk), poke ? "R9 read addr" : "R2 read addr",
                      64'(rd_addr), 64'(rbase + 32'(8*rk)));
                check(int'(rd_remain) == rem, "R3 remain", 64'(rd_remain), 64'(rem));
                used = (rk == 0) ? 8 - so : 8;
                if (used > rem) used = rem;
                rem -= used;
                rk++;
            end
            if (out_valid && out_ready) begin
                if (q_addr.size() == 0) begin
                    check(1'b0, "R7 extra output", 64'(out_addr), 64'd0);
                end else begin
                    logic [63:0] m;
                    logic [63:0] ed;
                    logic [31:0] ea;
                    logic [7:0]  eb;
                    ea = q_addr.pop_front();
                    ed = q_data.pop_front();
                    eb = q_be.pop_front();
                    for (int b = 0; b < 8; b++) m[8*b +: 8] = {8{eb[b]}};
                    check(out_addr == ea, "R4 write addr", 64'(out_addr), 64'(ea));
                    check(out_be == eb, "R6 enables", 64'(out_be), 64'(eb));
                    check((out_data & m) == ed, poke ? "R9 data" : "R5 data",
                          out_data & m, ed);
                end
            end
            if (done) begin
                check(rk == nin, "R7 read count", 64'(rk), 64'(nin));
                check(q_addr.size() == 0, "R7 output count", 64'(q_addr.size()), 64'd0);
                check(rd_remain == 16'd0, "R3 remain at done", 64'(rd_remain), 64'd0);
                if (n == 0)
                    check(iter == 1, "R1 zero count done", 64'(iter), 64'd1);
                else if (pv == 100 && pr == 100)
                    check(iter == nout + lead + 1, "R8 cycle count", 64'(iter),
                          64'(nout + lead + 1));
                break;
            end
            if (iter > 4000) begin
                check(1'b0, "R10 transfer hung", 64'(iter), 64'd0);
                break;
            end
        end
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b0;
        start     = 1'b0;
        #4;
        check(!busy && !done && !out_valid && !in_ready, "R10 idle after done",
              {60'b0, busy, done, out_valid, in_ready}, 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 64'd0, 64'd1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        #4;
        check(!busy && !done && !in_ready && !out_valid, "R10 reset state",
              {60'b0, busy, done, in_ready, out_valid}, 64'd0);
        rst_n = 1'b1;

        xfer(32'h100, 32'h200, 16, 100, 100, 0);   // both aligned
        xfer(32'h103, 32'h205, 20, 100, 100, 0);   // destination ahead, flush
        xfer(32'h106, 32'h201, 30, 100, 100, 0);   // source ahead, prime
        xfer(32'h105, 32'h205, 3, 100, 100, 0);    // one partial word
        xfer(32'h107, 32'h200, 1, 100, 100, 0);    // prime then flush
        xfer(32'h100, 32'h207, 2, 100, 100, 0);    // straddles a boundary
        xfer(32'h102, 32'h202, 0, 100, 100, 0);    // zero count R1
        xfer(32'h104, 32'h203, 13, 100, 100, 0);   // source ahead, no flush
        xfer(32'h101, 32'h306, 200, 60, 55, 1);    // long, stalls, stray start R9
        for (int s = 0; s < 8; s++)
            for (int d = 0; d < 8; d++) begin
                xfer(32'h400 + s, 32'h800 + d, 9 + ((s + d) % 8), 100, 100, 0);
                xfer(32'h400 + s, 32'h800 + d, 1 + ((s * 3 + d) % 17), 50, 40, 0);
            end
        summary();
    end

endmodule